// File: doc/BRIEF.md
# Double-Buffered Range-Programmable Converter Register Front End

This block is the digital register interface of an 18-bit converter with a selectable output range. A code word and a 3-bit range word each travel through two stages: a staging (input) register that the host loads with an active-low write strobe, and an active register that drives the converter. One update strobe moves both staging registers into the active registers together. Because of this, a range change and the matching code change reach the converter on the same clock, and several parts on one bus can switch at the same moment.

The host reads any of the four registers back over the same pins it writes through. Each bidirectional port is split into an input bus, an output bus and an output enable. While read is high, the update pin does not update: it chooses whether the staging or the active register of the selected port is read. An asynchronous clear forces both code registers to the code that gives 0 V in the active range and leaves the range registers untouched. A strap input fixes the range to the value on the range pins, and the range port then ignores writes, updates and reads. The control pins pass through a synchroniser of `SYNC_STAGES` flops into the system clock domain. `rst_n` is a synchronous power-on reset, and `clr_n` acts asynchronously.

Top module: `dbuf_dac_regs`

## Requirements
- R1: After power-on reset with `fixed_span` low, `act_span` is 3'b000, `act_code` is 0, and `data_oe` and `span_oe` are both 0.
- R2: While `wr_n` is low, `rd` is low and `sel_span` is 0, the code staging register follows `data_in`. It keeps the last value after `wr_n` rises, and `act_code` does not change.
- R3: While `wr_n` is low, `rd` is low and `sel_span` is 1, the range staging register follows `span_in`. `act_span` does not change.
- R4: While `upd` is high and `rd` is low, both staging registers are copied into their active registers, whatever the value of `sel_span`.
- R5: While `rd` is high, write strobes change no staging register and `upd` changes no active register.
- R6: While `rd` is high, only the port chosen by `sel_span` (0 = code, 1 = range) asserts its output enable. It shows the staging register when `upd` is 0 and the active register when `upd` is 1.
- R7: A low on `clr_n` at once loads both code registers with the 0 V code for `act_span`: 0x00000 for 000 and 001, 0x20000 for 010, 011 and 100, 0x10000 for 101. The range registers keep their values.
- R8: With the reserved range codes 110 and 111 active, clear loads 0x00000.
- R9: With `fixed_span` high, both range registers follow `span_in`. Range-port writes and updates are ignored, `span_oe` stays 0, and reset loads the code registers with the 0 V code of the strapped range.
- R10: With `wr_n` held low and `upd` held high (both stages transparent), `act_code` follows `data_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| wr_n | input | 1 | Active-low write strobe |
| upd | input | 1 | Update strobe; selects the readback register while `rd` is high |
| rd | input | 1 | Readback enable |
| sel_span | input | 1 | Port select: 0 code port, 1 range port |
| clr_n | input | 1 | Asynchronous active-low clear to 0 V code |
| fixed_span | input | 1 | Strap: range fixed by `span_in` |
| data_in | input | 18 | Code port input side |
| data_out | output | 18 | Code port output side |
| data_oe | output | 1 | Code port output enable |
| span_in | input | 3 | Range port input side / strap pins |
| span_out | output | 3 | Range port output side |
| span_oe | output | 1 | Range port output enable |
| act_code | output | 18 | Active code to the converter |
| act_span | output | 3 | Active range to the converter |

## Verification
A change on a strobe reaches the register logic after `SYNC_STAGES` clock edges and is loaded on the next edge. Readback enables therefore follow `rd` after two edges, and a transparent code passes through to `act_code` after about four edges. The bench changes every input on a falling edge, waits four cycles and samples on a later falling edge, so each result it reads has already settled. Clear is the one asynchronous path: the bench checks it 2 ns after `clr_n` falls, with no clock edge in between.

// File: rtl/dac_if_pkg.sv
// Package: shared range codes and the 0 V code class for the register front end.
// Assumes a 3-bit range word; codes 110 and 111 are reserved.
package dac_if_pkg;
    localparam int SPAN_W = 3;

    localparam logic [SPAN_W-1:0] RNG_U5    = 3'b000;
    localparam logic [SPAN_W-1:0] RNG_U10   = 3'b001;
    localparam logic [SPAN_W-1:0] RNG_B5    = 3'b010;
    localparam logic [SPAN_W-1:0] RNG_B10   = 3'b011;
    localparam logic [SPAN_W-1:0] RNG_B2P5  = 3'b100;
    localparam logic [SPAN_W-1:0] RNG_SKEW  = 3'b101;

    typedef enum logic [1:0] {
        MID_ZERO    = 2'd0,
        MID_HALF    = 2'd1,
        MID_QUARTER = 2'd2
    } zc_kind_t;

    // Which fraction of full scale gives 0 V in a range.
    function automatic zc_kind_t zero_kind(input logic [SPAN_W-1:0] rng);
        case (rng)
            RNG_B5, RNG_B10, RNG_B2P5: zero_kind = MID_HALF;
            RNG_SKEW:                  zero_kind = MID_QUARTER;
            default:                   zero_kind = MID_ZERO;
        endcase
    endfunction
endpackage

// File: rtl/strobe_sync.sv
// Module: strobe_sync
// Brings a group of asynchronous control pins into the clock domain through
// STAGES flops per bit. Assumes the pins are level signals held for several
// clocks; no pulse shorter than a clock is caught.
module strobe_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stg [STAGES];

    // First stage samples the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= pin_i;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        // Later stages shift the sample on.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
        end
    end

    assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/span_regs.sv
// Module: span_regs
// Range staging and active registers. In strap mode both registers follow
// the strap pins on every clock and the load strobes are ignored. Clear
// does not touch these registers.
module span_regs
    import dac_if_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fixed,
    input  logic              ld_in,
    input  logic              ld_dac,
    input  logic [SPAN_W-1:0] bus_in,
    output logic [SPAN_W-1:0] in_q,
    output logic [SPAN_W-1:0] dac_q
);
    // Staging register: strap value, reset value or host write.
    always_ff @(posedge clk) begin
        if (fixed)       in_q <= bus_in;
        else if (!rst_n) in_q <= RNG_U5;
        else if (ld_in)  in_q <= bus_in;
    end

    // Active register: strap value, reset value or update copy.
    always_ff @(posedge clk) begin
        if (fixed)       dac_q <= bus_in;
        else if (!rst_n) dac_q <= RNG_U5;
        else if (ld_dac) dac_q <= in_q;
    end

    p_strap_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fixed |=> (dac_q == $past(bus_in)));

    p_span_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fixed && !ld_dac) |=> $stable(dac_q));
endmodule

// File: rtl/data_regs.sv
// Module: data_regs
// Code staging and active registers. Clear is asynchronous and loads both
// registers with the 0 V code of the active range. Power-on reset is
// synchronous and uses the range that the top passes in for reset.
module data_regs
    import dac_if_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              ld_in,
    input  logic              ld_dac,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [SPAN_W-1:0] span_act,
    input  logic [SPAN_W-1:0] span_por,
    output logic [DATA_W-1:0] in_q,
    output logic [DATA_W-1:0] dac_q
);
    localparam logic [DATA_W-1:0] CODE_HALF    = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] CODE_QUARTER = {2'b01, {(DATA_W-2){1'b0}}};

    // Map a range to its 0 V code at this data width.
    function automatic logic [DATA_W-1:0] mid_code(input logic [SPAN_W-1:0] rng);
        case (zero_kind(rng))
            MID_HALF:    mid_code = CODE_HALF;
            MID_QUARTER: mid_code = CODE_QUARTER;
            default:     mid_code = '0;
        endcase
    endfunction

    logic [DATA_W-1:0] clr_code;
    logic [DATA_W-1:0] por_code;

    // 0 V codes for clear (active range) and for reset (reset range).
    always_comb begin
        clr_code = mid_code(span_act);
        por_code = mid_code(span_por);
    end

    // Staging register: clear, reset or host write.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)      in_q <= clr_code;
        else if (!rst_n) in_q <= por_code;
        else if (ld_in)  in_q <= bus_in;
    end

    // Active register: clear, reset or update copy.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)      dac_q <= clr_code;
        else if (!rst_n) dac_q <= por_code;
        else if (ld_dac) dac_q <= in_q;
    end

    p_clear_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (dac_q == clr_code && in_q == clr_code));

    p_in_hold_r2: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        !ld_in |=> $stable(in_q));

    p_dac_copy_r4: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        ld_dac |=> (dac_q == $past(in_q)));
endmodule

// File: rtl/dbuf_dac_regs.sv
// Module: dbuf_dac_regs (top)
// Double-buffered code and range registers with readback over split
// bidirectional ports. The control pins are synchronised. Write and update
// act as levels, so holding both strobes open gives a transparent path and
// driving them from one clock gives master-slave loading. Assumes the data
// and range pins are stable while their strobe is open.
module dbuf_dac_regs
    import dac_if_pkg::*;
#(
    parameter int DATA_W      = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              upd,
    input  logic              rd,
    input  logic              sel_span,
    input  logic              clr_n,
    input  logic              fixed_span,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    input  logic [SPAN_W-1:0] span_in,
    output logic [SPAN_W-1:0] span_out,
    output logic              span_oe,
    output logic [DATA_W-1:0] act_code,
    output logic [SPAN_W-1:0] act_span
);
    localparam int CTL_W = 4;

    logic [CTL_W-1:0]  ctl_s;
    logic              wr_n_s, upd_s, rd_s, sel_s;
    logic              ld_in, ld_dac;
    logic [DATA_W-1:0] d_in_q, d_dac_q;
    logic [SPAN_W-1:0] s_in_q, s_dac_q;
    logic [SPAN_W-1:0] span_por;

    strobe_sync #(
        .WIDTH   (CTL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b0001)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({sel_span, rd, upd, wr_n}),
        .sync_o (ctl_s)
    );

    // Decode the synchronised strobes into load enables.
    always_comb begin
        {sel_s, rd_s, upd_s, wr_n_s} = ctl_s;
        ld_in    = !wr_n_s && !rd_s;
        ld_dac   = upd_s && !rd_s;
        span_por = fixed_span ? span_in : RNG_U5;
    end

    data_regs #(.DATA_W(DATA_W)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (clr_n),
        .ld_in    (ld_in && !sel_s),
        .ld_dac   (ld_dac),
        .bus_in   (data_in),
        .span_act (s_dac_q),
        .span_por (span_por),
        .in_q     (d_in_q),
        .dac_q    (d_dac_q)
    );

    span_regs u_span (
        .clk    (clk),
        .rst_n  (rst_n),
        .fixed  (fixed_span),
        .ld_in  (ld_in && sel_s),
        .ld_dac (ld_dac),
        .bus_in (span_in),
        .in_q   (s_in_q),
        .dac_q  (s_dac_q)
    );

    // Readback: selected port drives, update pin picks the register.
    always_comb begin
        data_oe  = rd_s && !sel_s;
        span_oe  = rd_s && sel_s && !fixed_span;
        data_out = data_oe ? (upd_s ? d_dac_q : d_in_q) : '0;
        span_out = span_oe ? (upd_s ? s_dac_q : s_in_q) : '0;
        act_code = d_dac_q;
        act_span = s_dac_q;
    end

    p_read_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        rd_s |=> $stable(act_code));

    p_strap_no_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fixed_span |-> !span_oe);

    p_one_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_oe, span_oe}));
endmodule

// File: tb/tb_dbuf_dac_regs.sv
module tb_dbuf_dac_regs;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_n = 1'b1, upd = 1'b0, rd = 1'b0, sel_span = 1'b0;
    logic          clr_n = 1'b1, fixed_span = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic [2:0]    span_in = '0;
    logic [DW-1:0] data_out, act_code;
    logic [2:0]    span_out, act_span;
    logic          data_oe, span_oe;

    int n_tests = 0;
    int n_fail  = 0;

    logic [DW-1:0] m_din, m_dac;
    logic [2:0]    m_sin, m_sdac;

    dbuf_dac_regs dut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .upd(upd), .rd(rd),
        .sel_span(sel_span), .clr_n(clr_n), .fixed_span(fixed_span),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .span_in(span_in), .span_out(span_out), .span_oe(span_oe),
        .act_code(act_code), .act_span(act_span)
    );

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] zc(input logic [2:0] s);
        if (s == 3'd2 || s == 3'd3 || s == 3'd4) return 18'h20000;
        if (s == 3'd5) return 18'h10000;
        return 18'h00000;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_act(input string req);
        chk(act_code == m_dac, req, 32'(act_code), 32'(m_dac));
        chk(act_span == m_sdac, req, 32'(act_span), 32'(m_sdac));
    endtask

    task automatic do_write(input bit sel, input logic [DW-1:0] val);
        sel_span = sel;
        if (sel) begin
            if (!fixed_span) span_in = val[2:0];
        end else data_in = val;
        step(1); wr_n = 1'b0; step(4); wr_n = 1'b1; step(4);
        if (!sel) m_din = val;
        else if (!fixed_span) m_sin = val[2:0];
    endtask

    task automatic do_update();
        upd = 1'b1; step(4); upd = 1'b0; step(4);
        m_dac = m_din;
        if (!fixed_span) m_sdac = m_sin;
    endtask

    task automatic do_read(input bit sel, input bit dac_sel, input string req);
        sel_span = sel; step(1);
        rd = 1'b1; step(4);
        if (dac_sel) begin upd = 1'b1; step(4); end
        if (!sel) begin
            chk(data_oe && !span_oe, req, {30'd0, data_oe, span_oe}, 32'h2);
            chk(data_out == (dac_sel ? m_dac : m_din), req, 32'(data_out),
                32'(dac_sel ? m_dac : m_din));
        end else if (!fixed_span) begin
            chk(span_oe && !data_oe, req, {30'd0, data_oe, span_oe}, 32'h1);
            chk(span_out == (dac_sel ? m_sdac : m_sin), req, 32'(span_out),
                32'(dac_sel ? m_sdac : m_sin));
        end else begin
            chk(!span_oe && !data_oe, "R9 strap read", {30'd0, data_oe, span_oe}, 32'h0);
        end
        upd = 1'b0; step(4); rd = 1'b0; step(4);
    endtask

    task automatic do_clear(input string req);
        logic [2:0] s0;
        s0 = act_span;
        clr_n = 1'b0; #2;
        chk(act_code == zc(m_sdac), req, 32'(act_code), 32'(zc(m_sdac)));
        chk(act_span == s0, req, 32'(act_span), 32'(s0));
        m_din = zc(m_sdac); m_dac = zc(m_sdac);
        step(1); clr_n = 1'b1; step(2);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; step(4); rst_n = 1'b1; step(2);
        m_sin  = fixed_span ? span_in : 3'd0;
        m_sdac = m_sin;
        m_din  = zc(m_sdac); m_dac = m_din;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        step(2);
        do_reset();
        // R1: reset state
        chk(act_code == 0, "R1 code", 32'(act_code), 0);
        chk(act_span == 0, "R1 span", 32'(act_span), 0);
        chk(!data_oe && !span_oe, "R1 oe", {30'd0, data_oe, span_oe}, 0);

        // R2/R6: stage mid-scale, read staging then active, then update
        do_write(1'b0, 18'h20000);
        chk_act("R2 act unchanged");
        do_read(1'b0, 1'b0, "R6 read staging");
        do_read(1'b0, 1'b1, "R6 read active");
        do_update();
        chk_act("R4 update code");

        // R3/R4: range 010 at 0x20000, then swap together
        do_write(1'b1, 18'd2);
        chk_act("R3 act span unchanged");
        do_read(1'b1, 1'b0, "R6 span staging");
        do_update();
        chk_act("R4 range change");
        do_write(1'b1, 18'd3);
        do_write(1'b0, 18'h30000);
        sel_span = 1'b1;
        do_update();
        chk_act("R4 update with span select");

        // R5: write blocked while reading
        sel_span = 1'b0; step(1); rd = 1'b1; step(4);
        data_in = 18'h0ABCD; wr_n = 1'b0; step(4); wr_n = 1'b1; step(4);
        chk(data_out == m_din, "R5 write blocked", 32'(data_out), 32'(m_din));
        rd = 1'b0; step(4);
        do_read(1'b0, 1'b0, "R5 staging intact");
        // R5: update blocked while reading
        do_write(1'b0, 18'h00123);
        rd = 1'b1; step(4); upd = 1'b1; step(4);
        chk(act_code == m_dac, "R5 update blocked", 32'(act_code), 32'(m_dac));
        upd = 1'b0; step(4); rd = 1'b0; step(4);
        chk_act("R5 after read");

        // R7: clear in each legal range
        for (int s = 0; s < 6; s++) begin
            do_write(1'b1, 18'(s));
            do_update();
            do_clear("R7 clear code");
        end
        // R8: reserved ranges
        do_write(1'b1, 18'd6); do_update(); do_clear("R8 reserved 110");
        do_write(1'b1, 18'd7); do_update(); do_clear("R8 reserved 111");

        // R10: transparent path
        sel_span = 1'b0; data_in = 18'h1F00F; wr_n = 1'b0; upd = 1'b1; step(6);
        chk(act_code == 18'h1F00F, "R10 transparent", 32'(act_code), 32'h1F00F);
        data_in = 18'h00F0F; step(6);
        chk(act_code == 18'h00F0F, "R10 transparent follow", 32'(act_code), 32'h00F0F);
        wr_n = 1'b1; upd = 1'b0; step(4);
        m_din = 18'h00F0F; m_dac = m_din; m_sdac = m_sin;
        chk_act("R10 settle");

        // Random mix
        for (int i = 0; i < 300; i++) begin
            int op;
            op = $urandom_range(0, 5);
            case (op)
                0: do_write(1'b0, 18'($urandom_range(0, 18'h3FFFF)));
                1: do_write(1'b1, 18'($urandom_range(0, 5)));
                2: begin do_update(); chk_act("R4 random update"); end
                3: do_read(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R6 random read");
                4: do_clear("R7 random clear");
                default: chk_act("R2 random hold");
            endcase
        end

        // R9: strap mode
        fixed_span = 1'b1; span_in = 3'b101;
        do_reset();
        chk(act_span == 3'b101, "R9 strap span", 32'(act_span), 32'h5);
        chk(act_code == 18'h10000, "R9 strap por code", 32'(act_code), 32'h10000);
        do_write(1'b1, 18'd1);
        do_update();
        chk_act("R9 span write ignored");
        do_read(1'b1, 1'b0, "R9 strap read");
        do_write(1'b0, 18'h3FFFF);
        do_update();
        chk_act("R9 code update");
        do_clear("R9 strap clear");

        summary();
        $finish;
    end
endmodule